// File: doc/BRIEF.md
# SPI Command Slave with Register Bank

This block is the host-facing front end of a bridge controller. An external SPI master drives four wires: clock, data in, data out and an active-low select. The block runs entirely on the local system clock and oversamples those wires through synchronizer chains. It assembles incoming bits into bytes and parses a framed, byte-oriented command protocol. The local commands read and write a bank of ten 8-bit configuration registers, return a two-byte revision code and switch the serial bit order. Transaction commands for the serial bus engine are not executed here. Their bytes are passed onward through a forwarding port.

The register bank is shared with the other blocks of the chip. Its full contents are brought out as a flat vector, and a client write port lets those blocks update registers at any time, independent of SPI traffic. Clock idles high. The slave samples data on the rising clock edge and changes its output after the falling edge. The output enable follows the select line.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset the order is MSB-first, `miso_oe` is 0, and every register reads 0x00 except address 2, which holds 0xA0.
- R2: The frame 0x20, address, value writes exactly one register. Any further bytes in the same select-low frame have no effect on any register.
- R3: The frame 0x21, address, one ignored byte returns the register value as the fourth byte on MISO. An address of 10 or above reads as 0x00, and a write to such an address changes no register.
- R4: The frame 0x18, value sets MSB-first for 0x81 and LSB-first for 0x42. Every other value leaves the order unchanged. The new order applies from the next byte.
- R5: The frame 0x40, one ignored byte returns the revision as two further bytes, high byte first. The defaults are 0x02 then 0x17 (revision 2.17).
- R6: In LSB-first order, bit 0 of each byte is the first bit both received and transmitted. In MSB-first order, bit 7 is first.
- R7: Raising the select line in the middle of a command, even partway through a byte, discards the partial command. The next frame parses its first byte as an opcode.
- R8: `miso_oe` is low whenever select was high two system clocks earlier. MISO carries 0x00 on every byte that is not a response byte.
- R9: A frame whose opcode is 0x00, 0x01, 0x02, 0x03, 0x06 or 0x09 pulses `fwd_valid` once per byte, with the byte on `fwd_data`. `fwd_sof` is asserted with the opcode byte, and `fwd_eof` pulses once after select rises. Any other unlisted opcode forwards nothing.
- R10: A one-cycle pulse on the client write port stores the data in the addressed register. The value is visible on `cfg_regs` and to SPI reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI clock from master, idles high |
| mosi | input | 1 | Serial data from master |
| cs_n | input | 1 | Active-low select |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| cli_wr_en | input | 1 | Client register write strobe |
| cli_wr_addr | input | 8 | Client register write address |
| cli_wr_data | input | 8 | Client register write data |
| cfg_regs | output | NREG*8 | All register contents, register i at bits [8i+7:8i] |
| fwd_valid | output | 1 | Forwarded transaction byte strobe |
| fwd_data | output | 8 | Forwarded transaction byte |
| fwd_sof | output | 1 | Marks the opcode byte of a forwarded frame |
| fwd_eof | output | 1 | One-cycle pulse after a forwarded frame ends |

## Verification
A parser stuck in the wrong state shows up one byte later. Either MISO returns a non-zero byte where silence is due, or `cfg_regs` changes on the wrong byte of a frame. The bench compares both against its own model at every frame end. A bit-order error corrupts the asymmetric revision bytes the first time they are read after an order change. Synchronizer or output-enable faults show up within two clocks of a select edge, because the enable is compared against a delayed copy of select on every clock.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_REG_WR   = 8'h20;
  localparam logic [BYTE_W-1:0] OP_REG_RD   = 8'h21;
  localparam logic [BYTE_W-1:0] OP_ORDER    = 8'h18;
  localparam logic [BYTE_W-1:0] OP_REV      = 8'h40;
  localparam logic [BYTE_W-1:0] ORDER_MSB   = 8'h81;
  localparam logic [BYTE_W-1:0] ORDER_LSB   = 8'h42;
  localparam logic [BYTE_W-1:0] IDLE_BYTE   = 8'h00;

  typedef enum logic [3:0] {
    PS_OPCODE,
    PS_WR_ADDR,
    PS_WR_DATA,
    PS_RD_ADDR,
    PS_RD_TURN,
    PS_ORDER,
    PS_REV_TURN,
    PS_REV_LOW,
    PS_FORWARD,
    PS_DRAIN
  } parse_state_t;

  // Reverse bit order of one byte.
  function automatic logic [BYTE_W-1:0] flip8(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

  // Bit transmitted in slot idx of a byte for the given order.
  function automatic logic pick_bit(input logic [BYTE_W-1:0] b,
                                    input logic [2:0] idx,
                                    input logic msb);
    return msb ? b[3'd7 - idx] : b[idx];
  endfunction

  // Turn the arrival-ordered shift contents into the byte value.
  function automatic logic [BYTE_W-1:0] arrange(input logic [BYTE_W-1:0] arrival,
                                                input logic msb);
    return msb ? arrival : flip8(arrival);
  endfunction

  // Opcodes handed to the serial bus transaction engine.
  function automatic logic is_xfer_op(input logic [BYTE_W-1:0] op);
    case (op)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h06, 8'h09: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction

  // Order setting after an order-select byte.
  function automatic logic next_order(input logic [BYTE_W-1:0] v, input logic cur);
    if (v == ORDER_MSB) return 1'b1;
    if (v == ORDER_LSB) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              cs_n,
  input  logic              msb_first,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              cs_active,
  output logic              cs_end,
  output logic              sclk_rise,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso,
  output logic              miso_oe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_s, mosi_s, cs_s;
  logic                   sclk_d, cs_act_d;
  logic [2:0]             bit_cnt;
  logic [BYTE_W-1:0]      rx_sh, tx_q, arrival;
  logic                   miso_q, sclk_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '1;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[TOP-1:0], sclk};
      cs_s   <= {cs_s[TOP-1:0], cs_n};
      mosi_s <= {mosi_s[TOP-1:0], mosi};
    end
  end

  assign cs_active = ~cs_s[TOP];
  assign cs_end    = cs_act_d & ~cs_active;
  assign sclk_rise = cs_active & sclk_s[TOP] & ~sclk_d;
  assign sclk_fall = cs_active & ~sclk_s[TOP] & sclk_d;
  assign arrival   = {rx_sh[BYTE_W-2:0], mosi_s[TOP]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b1;
      cs_act_d   <= 1'b0;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      rx_byte    <= '0;
      byte_valid <= 1'b0;
      tx_q       <= '0;
      miso_q     <= 1'b0;
    end else begin
      sclk_d     <= sclk_s[TOP];
      cs_act_d   <= cs_active;
      byte_valid <= 1'b0;
      if (!cs_active) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_q    <= '0;
        miso_q  <= 1'b0;
      end else begin
        if (tx_load) tx_q <= tx_byte;
        if (sclk_rise) begin
          rx_sh   <= arrival;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_valid <= 1'b1;
            rx_byte    <= arrange(arrival, msb_first);
          end
        end else if (sclk_fall) begin
          miso_q <= pick_bit(tx_q, bit_cnt, msb_first);
        end
      end
    end
  end

  assign miso_oe = cs_active;
  assign miso    = miso_q & cs_active;
endmodule

// File: rtl/spi_cmd_parser.sv
module spi_cmd_parser
  import spi_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] REV_HI = 8'h02,
  parameter logic [BYTE_W-1:0] REV_LO = 8'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              cs_end,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              msb_first,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              fwd_valid,
  output logic [BYTE_W-1:0] fwd_data,
  output logic              fwd_sof,
  output logic              fwd_eof
);
  parse_state_t      state;
  logic [BYTE_W-1:0] addr_q;

  assign rd_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_OPCODE;
      addr_q    <= '0;
      msb_first <= 1'b1;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      tx_load   <= 1'b0;
      tx_byte   <= '0;
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
      fwd_sof   <= 1'b0;
      fwd_eof   <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      tx_load   <= 1'b0;
      fwd_valid <= 1'b0;
      fwd_sof   <= 1'b0;
      fwd_eof   <= 1'b0;
      if (cs_end) begin
        fwd_eof <= (state == PS_FORWARD);
        state   <= PS_OPCODE;
      end else if (byte_valid) begin
        tx_load <= 1'b1;
        tx_byte <= IDLE_BYTE;
        case (state)
          PS_OPCODE: begin
            if (rx_byte == OP_REG_WR)      state <= PS_WR_ADDR;
            else if (rx_byte == OP_REG_RD) state <= PS_RD_ADDR;
            else if (rx_byte == OP_ORDER)  state <= PS_ORDER;
            else if (rx_byte == OP_REV)    state <= PS_REV_TURN;
            else if (is_xfer_op(rx_byte)) begin
              state     <= PS_FORWARD;
              fwd_valid <= 1'b1;
              fwd_sof   <= 1'b1;
              fwd_data  <= rx_byte;
            end else begin
              state <= PS_DRAIN;
            end
          end
          PS_WR_ADDR: begin
            addr_q <= rx_byte;
            state  <= PS_WR_DATA;
          end
          PS_WR_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= addr_q;
            wr_data <= rx_byte;
            state   <= PS_DRAIN;
          end
          PS_RD_ADDR: begin
            addr_q <= rx_byte;
            state  <= PS_RD_TURN;
          end
          PS_RD_TURN: begin
            tx_byte <= rd_data;
            state   <= PS_DRAIN;
          end
          PS_ORDER: begin
            msb_first <= next_order(rx_byte, msb_first);
            state     <= PS_DRAIN;
          end
          PS_REV_TURN: begin
            tx_byte <= REV_HI;
            state   <= PS_REV_LOW;
          end
          PS_REV_LOW: begin
            tx_byte <= REV_LO;
            state   <= PS_DRAIN;
          end
          PS_FORWARD: begin
            fwd_valid <= 1'b1;
            fwd_data  <= rx_byte;
          end
          default: state <= PS_DRAIN;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cmd_pkg::*;
#(
  parameter int                NREG        = 10,
  parameter int                CLKDIV_ADDR = 2,
  parameter logic [BYTE_W-1:0] CLKDIV_RST  = 8'hA0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_wr_en,
  input  logic [BYTE_W-1:0]      spi_wr_addr,
  input  logic [BYTE_W-1:0]      spi_wr_data,
  input  logic                   cli_wr_en,
  input  logic [BYTE_W-1:0]      cli_wr_addr,
  input  logic [BYTE_W-1:0]      cli_wr_data,
  input  logic [BYTE_W-1:0]      rd_addr,
  output logic [BYTE_W-1:0]      rd_data,
  output logic [NREG*BYTE_W-1:0] regs_flat
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  function automatic logic [BYTE_W-1:0] reset_value(input int idx);
    return (idx == CLKDIV_ADDR) ? CLKDIV_RST : 8'h00;
  endfunction

  logic [BYTE_W-1:0] regs_arr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [BYTE_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      val <= reset_value(g);
      else if (spi_wr_en && spi_wr_addr == BYTE_W'(g)) val <= spi_wr_data;
      else if (cli_wr_en && cli_wr_addr == BYTE_W'(g)) val <= cli_wr_data;
    end
    assign regs_arr[g]                  = val;
    assign regs_flat[g*BYTE_W +: BYTE_W] = val;
  end

  always_comb begin
    rd_data = 8'h00;
    if (32'(rd_addr) < NREG) rd_data = regs_arr[rd_addr[IDX_W-1:0]];
  end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int                NREG        = 10,
  parameter int                SYNC_STAGES = 2,
  parameter int                CLKDIV_ADDR = 2,
  parameter logic [BYTE_W-1:0] CLKDIV_RST  = 8'hA0,
  parameter logic [BYTE_W-1:0] REV_HI      = 8'h02,
  parameter logic [BYTE_W-1:0] REV_LO      = 8'h17
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   mosi,
  input  logic                   cs_n,
  output logic                   miso,
  output logic                   miso_oe,
  input  logic                   cli_wr_en,
  input  logic [7:0]             cli_wr_addr,
  input  logic [7:0]             cli_wr_data,
  output logic [NREG*BYTE_W-1:0] cfg_regs,
  output logic                   fwd_valid,
  output logic [7:0]             fwd_data,
  output logic                   fwd_sof,
  output logic                   fwd_eof
);
  logic              cs_active, cs_end, sclk_rise, byte_valid, msb_first;
  logic              tx_load, spi_wr_en;
  logic [BYTE_W-1:0] rx_byte, tx_byte, rd_addr, rd_data, spi_wr_addr, spi_wr_data;

  spi_bit_engine #(.SYNC_STAGES(SYNC_STAGES)) u_bits (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .msb_first(msb_first), .tx_load(tx_load), .tx_byte(tx_byte),
    .cs_active(cs_active), .cs_end(cs_end), .sclk_rise(sclk_rise),
    .byte_valid(byte_valid), .rx_byte(rx_byte), .miso(miso), .miso_oe(miso_oe)
  );

  spi_cmd_parser #(.REV_HI(REV_HI), .REV_LO(REV_LO)) u_parse (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .rx_byte(rx_byte),
    .cs_end(cs_end), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(spi_wr_en), .wr_addr(spi_wr_addr), .wr_data(spi_wr_data),
    .msb_first(msb_first), .tx_load(tx_load), .tx_byte(tx_byte),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_sof(fwd_sof), .fwd_eof(fwd_eof)
  );

  spi_reg_bank #(.NREG(NREG), .CLKDIV_ADDR(CLKDIV_ADDR), .CLKDIV_RST(CLKDIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .spi_wr_en(spi_wr_en), .spi_wr_addr(spi_wr_addr), .spi_wr_data(spi_wr_data),
    .cli_wr_en(cli_wr_en), .cli_wr_addr(cli_wr_addr), .cli_wr_data(cli_wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_flat(cfg_regs)
  );
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
  parameter int         NREG        = 10,
  parameter int         SYNC_STAGES = 2,
  parameter int         CLKDIV_ADDR = 2,
  parameter logic [7:0] CLKDIV_RST  = 8'hA0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            miso_oe,
  input logic            cs_active,
  input logic            sclk_rise,
  input logic            byte_valid,
  input logic [7:0]      rx_byte,
  input logic            msb_first,
  input logic            spi_wr_en,
  input logic            fwd_valid,
  input logic            fwd_sof,
  input logic [NREG*8-1:0] cfg_regs
);
  logic [2:0] edge_cnt;
  logic [3:0] wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      wr_cnt   <= '0;
    end else if (!cs_active) begin
      edge_cnt <= '0;
      wr_cnt   <= '0;
    end else begin
      if (sclk_rise) edge_cnt <= edge_cnt + 3'd1;
      if (spi_wr_en && wr_cnt != 4'hF) wr_cnt <= wr_cnt + 4'd1;
    end
  end

  // R1: reset defaults
  p_reset_defaults_r1: assert property (@(posedge clk)
    !rst_n |=> (msb_first && cfg_regs[CLKDIV_ADDR*8 +: 8] == CLKDIV_RST));

  // R2: at most one register write per select-low frame
  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_wr_en |-> wr_cnt == 4'd0);

  // R4: order changes only right after a valid order-select byte
  p_order_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msb_first) |-> ($past(byte_valid) &&
      ($past(rx_byte) == 8'h81 || $past(rx_byte) == 8'h42)));

  // R7: a byte completes only on the eighth rising edge of the frame
  p_byte_on_eighth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (edge_cnt == 3'd0 && $past(sclk_rise)));

  // R8: output enable off once select has been high through the synchronizer
  p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, SYNC_STAGES) |-> !miso_oe);

  // R9: start-of-frame marker only with a forwarded opcode byte
  p_fwd_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sof |-> (fwd_valid && $past(byte_valid)));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(
  .NREG(NREG), .SYNC_STAGES(SYNC_STAGES), .CLKDIV_ADDR(CLKDIV_ADDR), .CLKDIV_RST(CLKDIV_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_oe(miso_oe), .cs_active(cs_active),
  .sclk_rise(sclk_rise), .byte_valid(byte_valid), .rx_byte(rx_byte),
  .msb_first(msb_first), .spi_wr_en(spi_wr_en), .fwd_valid(fwd_valid),
  .fwd_sof(fwd_sof), .cfg_regs(cfg_regs)
);

// File: tb/spi_cmd_slave_bench.sv
module spi_cmd_slave_bench;
  localparam int NREG = 10;
  localparam int HALF = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sclk, mosi, cs_n, miso, miso_oe;
  logic cli_wr_en;
  logic [7:0] cli_wr_addr, cli_wr_data;
  logic [NREG*8-1:0] cfg_regs;
  logic fwd_valid, fwd_sof, fwd_eof;
  logic [7:0] fwd_data;

  spi_cmd_slave u_spi_cmd_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .miso_oe(miso_oe), .cli_wr_en(cli_wr_en),
    .cli_wr_addr(cli_wr_addr), .cli_wr_data(cli_wr_data), .cfg_regs(cfg_regs),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_sof(fwd_sof), .fwd_eof(fwd_eof)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit bench_msb = 1;
  logic [7:0] model [NREG];
  logic [7:0] fwd_q [$];
  int sof_cnt = 0;
  int eof_cnt = 0;
  bit cs_h0 = 1, cs_h1 = 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // Reference for the enable: select delayed by two system clocks (R8).
  always @(posedge clk) begin
    if (!rst_n) begin
      cs_h1 = 1; cs_h0 = 1;
    end else begin
      cs_h1 = cs_h0; cs_h0 = cs_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (miso_oe !== !cs_h1) begin
        fails++;
        $display("FAIL R8 miso_oe: actual %0b expected %0b", miso_oe, !cs_h1);
      end
    end
    if (fwd_valid) fwd_q.push_back(fwd_data);
    if (fwd_sof) sof_cnt++;
    if (fwd_eof) eof_cnt++;
  end

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = bench_msb ? 7 - i : i;
      sclk = 1'b0;
      mosi = tx[idx];
      repeat (HALF) @(negedge clk);
      rx[idx] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic frame_begin();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_end();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(req, cfg_regs[i*8 +: 8], model[i], $sformatf("cfg_regs[%0d]", i));
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d, input bit extra);
    logic [7:0] r0, r1, r2, r3;
    frame_begin();
    xfer(8'h20, r0); xfer(a, r1); xfer(d, r2);
    r3 = 8'h00;
    if (extra) xfer(8'h77, r3);
    frame_end();
    chk("R8", r0 | r1 | r2 | r3, 8'h00, "idle response during write");
    if (int'(a) < NREG) model[a] = d;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] r;
    frame_begin();
    xfer(8'h21, r); xfer(a, r); xfer(8'hA5, r); xfer(8'h00, d);
    frame_end();
  endtask

  task automatic rev_read(output logic [7:0] hi, output logic [7:0] lo);
    logic [7:0] r;
    frame_begin();
    xfer(8'h40, r); xfer(8'h5C, r); xfer(8'h00, hi); xfer(8'h00, lo);
    frame_end();
  endtask

  task automatic set_order(input logic [7:0] v);
    logic [7:0] r;
    frame_begin();
    xfer(8'h18, r); xfer(v, r);
    frame_end();
    if (v == 8'h81) bench_msb = 1;
    else if (v == 8'h42) bench_msb = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d, hi, lo, r;
    int q0, e0, s0;
    rst_n = 0; sclk = 1; mosi = 0; cs_n = 1;
    cli_wr_en = 0; cli_wr_addr = 0; cli_wr_data = 0;
    for (int i = 0; i < NREG; i++) model[i] = (i == 2) ? 8'hA0 : 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", {7'd0, miso_oe}, 8'h00, "miso_oe after reset");
    check_regs("R1");

    // R5 revision in default MSB-first order (R1)
    rev_read(hi, lo);
    chk("R5", hi, 8'h02, "revision high");
    chk("R5", lo, 8'h17, "revision low");

    // R2 write then read back, R3 read path
    reg_write(8'h05, 8'h5A, 0);
    check_regs("R2");
    reg_read(8'h05, d);
    chk("R3", d, 8'h5A, "read reg 5");
    reg_read(8'h02, d);
    chk("R3", d, 8'hA0, "read reg 2 default");

    // R2 extra bytes after value ignored
    reg_write(8'h03, 8'hC3, 1);
    check_regs("R2");

    // R3 out-of-range address
    reg_write(8'h0C, 8'hEE, 0);
    check_regs("R3");
    reg_read(8'h0C, d);
    chk("R3", d, 8'h00, "read addr 0x0C");

    // R4 unlisted order value leaves MSB-first
    set_order(8'h55);
    rev_read(hi, lo);
    chk("R4", hi, 8'h02, "order unchanged high");
    chk("R4", lo, 8'h17, "order unchanged low");

    // R6 LSB-first in both directions
    set_order(8'h42);
    rev_read(hi, lo);
    chk("R6", hi, 8'h02, "lsb revision high");
    chk("R6", lo, 8'h17, "lsb revision low");
    reg_write(8'h07, 8'h3C, 0);
    check_regs("R6");
    reg_read(8'h07, d);
    chk("R6", d, 8'h3C, "lsb read reg 7");
    set_order(8'h81);
    reg_read(8'h07, d);
    chk("R4", d, 8'h3C, "msb restored read reg 7");

    // R7 abort after address, then mid-byte abort
    frame_begin(); xfer(8'h20, r); xfer(8'h04, r); frame_end();
    check_regs("R7");
    frame_begin(); xfer(8'h21, r); spi_bits(8'h04, 4, r); frame_end();
    reg_write(8'h04, 8'h96, 0);
    reg_read(8'h04, d);
    chk("R7", d, 8'h96, "fresh frame after abort");
    check_regs("R7");

    // R9 forwarding
    q0 = fwd_q.size(); e0 = eof_cnt; s0 = sof_cnt;
    frame_begin(); xfer(8'h01, r); xfer(8'h03, r); xfer(8'h50, r); frame_end();
    chk("R9", 8'(fwd_q.size() - q0), 8'd3, "forwarded byte count");
    if (fwd_q.size() - q0 == 3) begin
      chk("R9", fwd_q[q0],     8'h01, "forwarded opcode");
      chk("R9", fwd_q[q0 + 1], 8'h03, "forwarded byte 1");
      chk("R9", fwd_q[q0 + 2], 8'h50, "forwarded byte 2");
    end
    chk("R9", 8'(sof_cnt - s0), 8'd1, "sof pulses");
    chk("R9", 8'(eof_cnt - e0), 8'd1, "eof pulses");
    q0 = fwd_q.size(); e0 = eof_cnt;
    frame_begin(); xfer(8'h7E, r); xfer(8'h11, r); frame_end();
    chk("R9", 8'(fwd_q.size() - q0), 8'd0, "unknown opcode forwards nothing");
    chk("R9", 8'(eof_cnt - e0), 8'd0, "unknown opcode no eof");
    check_regs("R9");

    // R10 client write port
    cli_wr_en = 1; cli_wr_addr = 8'h06; cli_wr_data = 8'h99;
    @(negedge clk);
    cli_wr_en = 0;
    @(negedge clk);
    model[6] = 8'h99;
    check_regs("R10");
    reg_read(8'h06, d);
    chk("R10", d, 8'h99, "SPI read of client value");

    finish_run();
  end
endmodule